// File: doc/BRIEF.md
# Comma-Count Link Synchronization Monitor

This block watches the 10-bit code groups that leave a word aligner and reports whether the receive link can be trusted. Each cycle may carry one code group, marked by a valid strobe. An outside 8b/10b decoder supplies a flag that says whether that group decoded cleanly. The block itself only recognises the K28.5 comma.

While hunting, the block counts clean commas. Any decode error resets this count to zero. After a long unbroken run of commas it declares the link synchronized. While locked, it counts decode errors. The count of pending errors is cleared by a long enough stretch of clean groups. When errors pile up closely enough, the block drops back to hunting. The single output is a registered status level that downstream logic can use to gate the data path.

Top module: `cgsync_lock`

## Requirements
- R1: Asserting `rst` forces `sync_o` low on the next edge and clears the comma count, so a full run of commas is needed again after reset, even if reset arrives part way through a run or while locked.
- R2: Both K28.5 forms count as commas: 10'b0101111100 and 10'b1010000011.
- R3: While hunting, `sync_o` rises only after the 127th clean comma, counted since reset, since the last loss of sync, or since the last decode error. It stays low after 126.
- R4: A valid group with `cg_bad_i` high during hunting sets the comma count back to zero. This holds even when the data is a comma pattern.
- R5: A valid, clean group that is not a comma (for example 10'b1010101010) does not change the comma count during hunting, either up or down.
- R6: Cycles with `cg_valid_i` low change no count and no status, whatever `cg_data_i` and `cg_bad_i` carry.
- R7: While locked, `sync_o` falls after the third decode error when each error follows the previous one by at most 254 clean valid groups.
- R8: While locked, 255 consecutive clean valid groups clear the pending error count to zero.
- R9: One or two pending errors alone do not drop sync. After a loss of sync, the comma count starts again from zero.
- R10: `sync_o` is registered. It changes on the rising clock edge that samples the code group causing the change, and never earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cg_valid_i | input | 1 | A code group is present this cycle |
| cg_data_i | input | 10 | Word-aligned 10-bit code group |
| cg_bad_i | input | 1 | The decoder found this group invalid |
| sync_o | output | 1 | Link synchronized status |

## Verification
Every status change is due on the same rising edge that samples the deciding code group. No other register lies on the path. The bench therefore drives each group at the falling edge and reads `sync_o` 1 ns after the next rising edge.

Each boundary is probed from both sides:
- the 126th against the 127th comma;
- the second against the third error;
- 254 against 255 clean groups between errors.

In each case the first read must still show the old level, and the read after the deciding group must show the new one.

// File: rtl/cgsync_pkg.sv
package cgsync_pkg;

    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } link_state_e;

    // Classified view of one input cycle
    typedef struct packed {
        logic strobe;  // a code group is present
        logic bad;     // decoder flagged it
        logic comma;   // matches a K28.5 pattern
    } cg_class_t;

    localparam int unsigned CG_W = 10;
    localparam int unsigned N_COMMA_FORMS = 2;

    // The two running-disparity forms of K28.5
    localparam logic [CG_W-1:0] COMMA_FORMS [N_COMMA_FORMS] = '{
        10'b0101111100,
        10'b1010000011
    };

    function automatic logic is_k285(input logic [CG_W-1:0] cg);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < N_COMMA_FORMS; i++)
            if (cg == COMMA_FORMS[i]) hit = 1'b1;
        return hit;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/cg_classify.sv
module cg_classify
    import cgsync_pkg::*;
(
    input  logic            valid_i,
    input  logic [CG_W-1:0] data_i,
    input  logic            bad_i,
    output cg_class_t       cls_o
);
    logic [N_COMMA_FORMS-1:0] form_hit;

    generate
        for (genvar g = 0; g < N_COMMA_FORMS; g++) begin : g_form
            assign form_hit[g] = (data_i == COMMA_FORMS[g]);
        end
    endgenerate

    always_comb begin
        cls_o.strobe = valid_i;
        cls_o.bad    = valid_i & bad_i;
        cls_o.comma  = valid_i & ~bad_i & (|form_hit);
    end
endmodule

// File: rtl/cg_acq_counter.sv
module cg_acq_counter
    import cgsync_pkg::*;
#(
    parameter int unsigned ACQ_COMMAS = 127,
    localparam int unsigned AW = cnt_width(ACQ_COMMAS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active_i,
    input  cg_class_t     cls_i,
    output logic          done_o,
    output logic [AW-1:0] cnt_o
);
    localparam logic [AW-1:0] LAST = AW'(ACQ_COMMAS - 1);

    logic [AW-1:0] cnt_q;

    assign done_o = active_i & cls_i.comma & (cnt_q == LAST);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active_i) begin
            cnt_q <= '0;
        end else if (cls_i.strobe) begin
            if (cls_i.bad)
                cnt_q <= '0;
            else if (cls_i.comma)
                cnt_q <= done_o ? '0 : cnt_q + AW'(1);
        end
    end
endmodule

// File: rtl/cg_loss_monitor.sv
module cg_loss_monitor
    import cgsync_pkg::*;
#(
    parameter int unsigned ERR_LIMIT   = 3,
    parameter int unsigned GOOD_WINDOW = 255,
    localparam int unsigned EW = cnt_width(ERR_LIMIT),
    localparam int unsigned GW = cnt_width(GOOD_WINDOW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active_i,
    input  cg_class_t     cls_i,
    output logic          lose_o,
    output logic [EW-1:0] err_cnt_o
);
    localparam logic [EW-1:0] ERR_LAST  = EW'(ERR_LIMIT - 1);
    localparam logic [GW-1:0] GOOD_LAST = GW'(GOOD_WINDOW - 1);

    logic [EW-1:0] err_q;
    logic [GW-1:0] good_q;

    assign lose_o    = active_i & cls_i.bad & (err_q == ERR_LAST);
    assign err_cnt_o = err_q;

    always_ff @(posedge clk) begin
        if (rst || !active_i) begin
            err_q  <= '0;
            good_q <= '0;
        end else if (cls_i.strobe) begin
            if (cls_i.bad) begin
                err_q  <= lose_o ? '0 : err_q + EW'(1);
                good_q <= '0;
            end else if (err_q != '0) begin
                if (good_q == GOOD_LAST) begin
                    err_q  <= '0;
                    good_q <= '0;
                end else begin
                    good_q <= good_q + GW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/cgsync_lock.sv
module cgsync_lock
    import cgsync_pkg::*;
#(
    parameter int unsigned ACQ_COMMAS  = 127,
    parameter int unsigned ERR_LIMIT   = 3,
    parameter int unsigned GOOD_WINDOW = 255
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cg_valid_i,
    input  logic [CG_W-1:0] cg_data_i,
    input  logic            cg_bad_i,
    output logic            sync_o
);
    localparam int unsigned AW = cnt_width(ACQ_COMMAS);
    localparam int unsigned EW = cnt_width(ERR_LIMIT);

    cg_class_t     cls;
    link_state_e   state_q, state_d;
    logic          acq_done, lose;
    logic [AW-1:0] acq_cnt_w;
    logic [EW-1:0] err_cnt_w;

    cg_classify u_cls (
        .valid_i (cg_valid_i),
        .data_i  (cg_data_i),
        .bad_i   (cg_bad_i),
        .cls_o   (cls)
    );

    cg_acq_counter #(.ACQ_COMMAS(ACQ_COMMAS)) u_acq (
        .clk      (clk),
        .rst      (rst),
        .active_i (state_q == ST_HUNT),
        .cls_i    (cls),
        .done_o   (acq_done),
        .cnt_o    (acq_cnt_w)
    );

    cg_loss_monitor #(.ERR_LIMIT(ERR_LIMIT), .GOOD_WINDOW(GOOD_WINDOW)) u_loss (
        .clk       (clk),
        .rst       (rst),
        .active_i  (state_q == ST_LOCKED),
        .cls_i     (cls),
        .lose_o    (lose),
        .err_cnt_o (err_cnt_w)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:   if (acq_done) state_d = ST_LOCKED;
            ST_LOCKED: if (lose)     state_d = ST_HUNT;
            default:                 state_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HUNT;
        else     state_q <= state_d;
    end

    assign sync_o = (state_q == ST_LOCKED);
endmodule

// File: rtl/cgsync_lock_chk.sv
module cgsync_lock_chk
    import cgsync_pkg::*;
#(
    parameter int unsigned ERR_LIMIT = 3,
    parameter int unsigned AW = 7,
    parameter int unsigned EW = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            cg_valid_i,
    input logic [CG_W-1:0] cg_data_i,
    input logic            cg_bad_i,
    input logic            sync_o,
    input logic [AW-1:0]   acq_cnt,
    input logic [EW-1:0]   err_cnt
);
    // R1
    reset_low_chk: assert property (@(posedge clk) rst |=> !sync_o);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cg_valid_i |=> ($stable(sync_o) && $stable(acq_cnt) && $stable(err_cnt)));

    // R3
    rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!sync_o && !(cg_valid_i && !cg_bad_i && is_k285(cg_data_i))) |=> !sync_o);

    // R7
    drop_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_o && !(cg_valid_i && cg_bad_i)) |=> sync_o);

    // R4
    acq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!sync_o && cg_valid_i && cg_bad_i) |=> (acq_cnt == '0));

    // R5
    noncomma_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sync_o && cg_valid_i && !cg_bad_i && !is_k285(cg_data_i)) |=> $stable(acq_cnt));

    // R8
    err_bound_chk: assert property (@(posedge clk) disable iff (rst)
        err_cnt < EW'(ERR_LIMIT));
endmodule

bind cgsync_lock cgsync_lock_chk #(
    .ERR_LIMIT (ERR_LIMIT),
    .AW        (AW),
    .EW        (EW)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cg_valid_i (cg_valid_i),
    .cg_data_i  (cg_data_i),
    .cg_bad_i   (cg_bad_i),
    .sync_o     (sync_o),
    .acq_cnt    (acq_cnt_w),
    .err_cnt    (err_cnt_w)
);

// File: tb/cgsync_lock_tb_top.sv
`timescale 1ns/1ps
module cgsync_lock_tb_top;
    localparam logic [9:0] KA = 10'b0101111100;
    localparam logic [9:0] KB = 10'b1010000011;
    localparam logic [9:0] DG = 10'b1010101010;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cg_valid_i = 1'b0;
    logic [9:0] cg_data_i = '0;
    logic       cg_bad_i = 1'b0;
    logic       sync_o;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cgsync_lock dut_i (
        .clk(clk), .rst(rst), .cg_valid_i(cg_valid_i),
        .cg_data_i(cg_data_i), .cg_bad_i(cg_bad_i), .sync_o(sync_o)
    );

    task automatic put(input logic [9:0] d, input logic b);
        @(negedge clk);
        cg_valid_i = 1'b1; cg_data_i = d; cg_bad_i = b;
        @(posedge clk); #1;
        cg_valid_i = 1'b0; cg_bad_i = 1'b0;
    endtask

    task automatic idle(input logic [9:0] d, input logic b);
        @(negedge clk);
        cg_valid_i = 1'b0; cg_data_i = d; cg_bad_i = b;
        @(posedge clk); #1;
        cg_bad_i = 1'b0;
    endtask

    task automatic commas(input int n, input bit only_b);
        for (int i = 0; i < n; i++) put((only_b || i[0]) ? KB : KA, 1'b0);
    endtask

    task automatic goods(input int n);
        for (int i = 0; i < n; i++) put(DG, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
    endtask

    task automatic chk(input string req, input logic exp);
        checks++;
        if (sync_o !== exp) begin
            errors++;
            $display("FAIL %s sync_o actual=%b expected=%b", req, sync_o, exp);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 reset", 1'b0);

        // R2 R3 R10: both forms, 126 not enough, 127th locks
        commas(126, 1'b0);  chk("R3 after 126", 1'b0);
        commas(1, 1'b0);    chk("R10 R3 after 127", 1'b1);

        // R9 then R7 with no gap
        put(DG, 1'b1); put(DG, 1'b1); chk("R9 two errors", 1'b1);
        put(DG, 1'b1);                chk("R7 third error", 1'b0);

        // R1 reset restarts acquisition; R2 single form
        commas(100, 1'b0); do_reset(); chk("R1 reset mid hunt", 1'b0);
        commas(126, 1'b1); chk("R1 R2 restart 126", 1'b0);
        commas(1, 1'b1);   chk("R2 form B only 127", 1'b1);
        do_reset();        chk("R1 reset while locked", 1'b0);

        // R4 error with comma data clears count
        commas(126, 1'b0); put(KA, 1'b1); chk("R4 after bad", 1'b0);
        commas(126, 1'b0); chk("R4 126 after clear", 1'b0);
        commas(1, 1'b0);   chk("R4 127 after clear", 1'b1);
        put(DG, 1'b1); put(DG, 1'b1); put(DG, 1'b1); chk("R7 drop", 1'b0);

        // R9 count restarts after loss; R5 non-commas neutral
        for (int i = 0; i < 126; i++) begin
            put(i[0] ? KB : KA, 1'b0);
            if (i < 30) put(DG, 1'b0);
        end
        chk("R5 R9 126 with fillers", 1'b0);
        commas(1, 1'b0); chk("R5 127 with fillers", 1'b1);
        put(DG, 1'b1); put(DG, 1'b1); put(DG, 1'b1); chk("R7 drop", 1'b0);

        // R6 idle cycles in hunt
        commas(126, 1'b0);
        for (int i = 0; i < 10; i++) idle(i[0] ? KA : DG, i[0]);
        chk("R6 idle hunt", 1'b0);
        commas(1, 1'b0); chk("R6 lock after idles", 1'b1);
        for (int i = 0; i < 6; i++) idle(DG, 1'b1);
        chk("R6 idle locked", 1'b1);

        // R8 255 clean groups clear pending errors
        put(DG, 1'b1); goods(255); put(DG, 1'b1); put(DG, 1'b1);
        chk("R8 window cleared", 1'b1);
        put(DG, 1'b1); chk("R7 R8 third after clear", 1'b0);

        // R7 spacing of 254
        commas(127, 1'b0); chk("R3 relock", 1'b1);
        put(DG, 1'b1); goods(254); put(DG, 1'b1); goods(254);
        chk("R7 before third", 1'b1);
        put(DG, 1'b1); chk("R7 third within 254", 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule